// File: doc/BRIEF.md
# Card Presence Debouncer

This block watches the card-detect input of a card socket and turns its noisy, asynchronous level into clean insertion and removal events. The pin is brought into the clock domain by a two-stage synchronizer, converted to a "card present" level using a polarity setting, and then confirmed by periodic sampling. A new level is accepted only after it agrees on three successive samples. Insertion is sampled slowly and removal is sampled quickly, so a card must settle before it is reported, while a pulled card is seen sooner.

Each accepted event sets a sticky flag that software clears by pulsing a write-one-to-clear strobe. The two flags are combined into one card-detect flag, which is gated by an interrupt enable. When automatic shutdown is allowed, an accepted removal also produces a one-cycle request to the power-sequencing logic to stop activity and deactivate the card. Detection runs only while the enable input is high. The polarity setting is taken only while the block is disabled.

Top module: `card_detect_debounce`

## Requirements
- R1: After reset the insert flag, remove flag, combined flag, interrupt and deactivation request are all 0.
- R2: `pin_sts_o` shows the level of `cd_pin_i` two clock edges after it was applied, whether or not the block is enabled.
- R3: With the card present and stable when `en_i` rises, the insert flag sets exactly STABLE_N × INS_PER clock edges after the first enabled edge. An insertion that occurs later is reported between 2·INS_PER+3 and 3·INS_PER+2 edges after the pin change.
- R4: A removal is sampled every REM_PER clocks. It is reported between 2·REM_PER+3 and 3·REM_PER+2 edges after the pin change.
- R5: A pin excursion that cannot cover STABLE_N consecutive samples produces no event. A single-cycle pulse and any pulse of at most 2·INS_PER cycles during insertion sampling both fall in this class.
- R6: With polarity 0, a low pin means a card is present. With polarity 1, a high pin means a card is present.
- R7: The polarity is captured only while `en_i` is low. Changing `pol_i` while enabled has no effect on detection.
- R8: While `en_i` is low no event is produced, and the debounced state returns to "absent". Disabling while a card is present therefore raises no remove flag.
- R9: The insert and remove flags stay set until their clear strobe is pulsed. A pulsed strobe clears the flag on the next edge.
- R10: `cd_flag_o` is the OR of the two flags, and `cd_irq_o` is `cd_flag_o` gated by `irq_en_i`.
- R11: When `auto_deact_i` is 1, an accepted removal raises `deact_req_o` for exactly one cycle, on the same edge as the remove flag. When `auto_deact_i` is 0, `deact_req_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Detection enable |
| cd_pin_i | input | 1 | Raw card-detect pin, asynchronous |
| pol_i | input | 1 | Presence polarity: 0 = low means present, 1 = high means present |
| irq_en_i | input | 1 | Interrupt enable for the combined flag |
| auto_deact_i | input | 1 | Allow removal to request deactivation |
| ins_clr_i | input | 1 | Write-one-to-clear strobe for the insert flag |
| rem_clr_i | input | 1 | Write-one-to-clear strobe for the remove flag |
| pin_sts_o | output | 1 | Synchronized raw pin level |
| ins_flag_o | output | 1 | Sticky insertion flag |
| rem_flag_o | output | 1 | Sticky removal flag |
| cd_flag_o | output | 1 | OR of the two flags |
| cd_irq_o | output | 1 | Gated card-detect interrupt |
| deact_req_o | output | 1 | One-cycle deactivation request |

## Verification
The assertions assume the following about the inputs:
- Clear strobes are single-cycle pulses.
- `pol_i` is meaningful only while the block is disabled.
- The reset is applied before the enable.

The stimulus drives every input just after the falling clock edge and keeps `pol_i` changes inside disabled windows, except in the one test that deliberately flips it while enabled. Pin excursions in the noise sweeps are bounded in length, so that they can never span STABLE_N samples at the active period. Event latencies are checked against windows derived from the sampling periods and the two-edge synchronizer.

// File: rtl/card_detect_debounce.sv
module card_detect_debounce #(
  parameter int INS_PER  = 384,
  parameter int REM_PER  = 128,
  parameter int STABLE_N = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic cd_pin_i,
  input  logic pol_i,
  input  logic irq_en_i,
  input  logic auto_deact_i,
  input  logic ins_clr_i,
  input  logic rem_clr_i,
  output logic pin_sts_o,
  output logic ins_flag_o,
  output logic rem_flag_o,
  output logic cd_flag_o,
  output logic cd_irq_o,
  output logic deact_req_o
);
  localparam int PMAX = (INS_PER > REM_PER) ? INS_PER : REM_PER;
  localparam int PW   = (PMAX > 1) ? $clog2(PMAX) : 1;
  localparam int MW   = $clog2(STABLE_N + 1);

  logic [1:0]    sync_q;
  logic          pol_q;
  logic          present_q;
  logic [PW-1:0] pre_q;
  logic [MW-1:0] match_q;
  logic          ins_q, rem_q, deact_q;

  logic          pin_s, present_raw, differ, tick, flip;
  logic [PW-1:0] per_last;

  assign pin_s       = sync_q[1];
  assign present_raw = pol_q ? pin_s : ~pin_s;
  assign differ      = present_raw ^ present_q;
  assign per_last    = present_q ? PW'(REM_PER - 1) : PW'(INS_PER - 1);
  assign tick        = en_i && (pre_q == per_last);
  assign flip        = tick && differ && (match_q == MW'(STABLE_N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], cd_pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pol_q <= 1'b0;
    else if (!en_i) pol_q <= pol_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q     <= '0;
      match_q   <= '0;
      present_q <= 1'b0;
    end else if (!en_i) begin
      pre_q     <= '0;
      match_q   <= '0;
      present_q <= 1'b0;
    end else if (flip) begin
      pre_q     <= '0;
      match_q   <= '0;
      present_q <= ~present_q;
    end else if (tick) begin
      pre_q     <= '0;
      match_q   <= differ ? match_q + MW'(1) : '0;
    end else begin
      pre_q     <= pre_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_q   <= 1'b0;
      rem_q   <= 1'b0;
      deact_q <= 1'b0;
    end else begin
      ins_q   <= (flip && !present_q) || (ins_q && !ins_clr_i);
      rem_q   <= (flip &&  present_q) || (rem_q && !rem_clr_i);
      deact_q <= flip && present_q && auto_deact_i;
    end
  end

  assign pin_sts_o   = pin_s;
  assign ins_flag_o  = ins_q;
  assign rem_flag_o  = rem_q;
  assign cd_flag_o   = ins_q | rem_q;
  assign cd_irq_o    = cd_flag_o & irq_en_i;
  assign deact_req_o = deact_q;

  p_ins_from_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ins_flag_o) |-> present_q && !$past(present_q));
  p_rem_from_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rem_flag_o) |-> !present_q && $past(present_q));
  p_match_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match_q < MW'(STABLE_N));
  p_pol_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && $past(en_i) |-> $stable(pol_q));
  p_idle_absent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !present_q);
  p_sticky_ins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ins_flag_o && !ins_clr_i |=> ins_flag_o);
  p_sticky_rem_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rem_flag_o && !rem_clr_i |=> rem_flag_o);
  p_deact_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    deact_req_o |=> !deact_req_o);
  p_deact_with_rem_r11: assert property (@(posedge clk) disable iff (!rst_n)
    deact_req_o |-> rem_flag_o && !present_q && $past(present_q));
endmodule

// File: tb/card_detect_debounce_tb.sv
module card_detect_debounce_tb;
  localparam int IP = 12;
  localparam int RP = 4;
  localparam int SN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 0, cd_pin_i = 1, pol_i = 0, irq_en_i = 0, auto_deact_i = 0;
  logic ins_clr_i = 0, rem_clr_i = 0;
  logic pin_sts_o, ins_flag_o, rem_flag_o, cd_flag_o, cd_irq_o, deact_req_o;
  int checks = 0, errors = 0;
  int deact_cycles = 0;

  always #2.5 clk = ~clk;

  card_detect_debounce #(.INS_PER(IP), .REM_PER(RP), .STABLE_N(SN)) u_dut (
    .clk, .rst_n, .en_i, .cd_pin_i, .pol_i, .irq_en_i, .auto_deact_i,
    .ins_clr_i, .rem_clr_i, .pin_sts_o, .ins_flag_o, .rem_flag_o,
    .cd_flag_o, .cd_irq_o, .deact_req_o);

  always @(posedge clk) #1 if (deact_req_o) deact_cycles++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic drive_at_neg();
    @(negedge clk);
  endtask

  task automatic clr_flags();
    drive_at_neg();
    ins_clr_i = 1; rem_clr_i = 1;
    drive_at_neg();
    ins_clr_i = 0; rem_clr_i = 0;
  endtask

  // counts edges until flag (0=ins,1=rem) goes high, limit lim
  task automatic wait_flag(input bit which, input int lim, output int n);
    n = 0;
    for (int i = 0; i < lim; i++) begin
      @(posedge clk);
      #1;
      n++;
      if ((which ? rem_flag_o : ins_flag_o) == 1'b1) return;
    end
    n = -1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    edges(3);
    drive_at_neg();
    rst_n = 1;
    edges(1);
    // R1
    chk({ins_flag_o, rem_flag_o, cd_flag_o, cd_irq_o, deact_req_o} == 5'b0,
        "R1 reset outputs", {ins_flag_o, rem_flag_o, cd_flag_o, cd_irq_o, deact_req_o}, 0);

    // R2 synchronizer latency
    drive_at_neg();
    cd_pin_i = 0;
    edges(1);
    chk(pin_sts_o == 1'b1, "R2 after one edge", pin_sts_o, 1);
    edges(1);
    chk(pin_sts_o == 1'b0, "R2 after two edges", pin_sts_o, 0);

    for (int pol = 0; pol < 2; pol++) begin
      logic pres, abs_lvl;
      pres = (pol == 0) ? 1'b0 : 1'b1;
      abs_lvl = ~pres;
      drive_at_neg();
      en_i = 0; pol_i = pol[0]; cd_pin_i = abs_lvl; auto_deact_i = 1; irq_en_i = 0;
      edges(4);
      clr_flags();
      cd_pin_i = pres;
      edges(4);
      drive_at_neg();
      en_i = 1;
      // R3 R6 exact insertion latency from enable
      wait_flag(0, 200, n);
      chk(n == SN * IP, "R3 R6 insert latency at enable", n, SN * IP);
      chk(rem_flag_o == 0, "R6 no remove on insert", rem_flag_o, 0);
      // R10
      chk(cd_flag_o == 1 && cd_irq_o == 0, "R10 flag set irq masked", {cd_flag_o, cd_irq_o}, 2);
      drive_at_neg();
      irq_en_i = 1;
      edges(1);
      chk(cd_irq_o == 1, "R10 irq enabled", cd_irq_o, 1);
      // R9 sticky then clear
      edges(20);
      chk(ins_flag_o == 1, "R9 insert flag sticky", ins_flag_o, 1);
      drive_at_neg();
      ins_clr_i = 1;
      drive_at_neg();
      ins_clr_i = 0;
      chk(ins_flag_o == 0 && cd_flag_o == 0 && cd_irq_o == 0, "R9 R10 cleared",
          {ins_flag_o, cd_flag_o, cd_irq_o}, 0);
      // R5 single-cycle absent glitches at every offset
      for (int off = 0; off < RP * 3; off++) begin
        drive_at_neg();
        edges(off);
        cd_pin_i = abs_lvl;
        drive_at_neg();
        cd_pin_i = pres;
        edges(SN * RP + 6);
        chk(rem_flag_o == 0 && deact_cycles == 0, "R5 removal glitch ignored", rem_flag_o, 0);
      end
      // R7 flip pol_i while enabled; removal must follow captured polarity
      drive_at_neg();
      pol_i = ~pol_i;
      deact_cycles = 0;
      cd_pin_i = abs_lvl;
      wait_flag(1, 100, n);
      chk(n >= 2 * RP + 3 && n <= 3 * RP + 2, "R4 R7 removal latency", n, 3 * RP);
      edges(6);
      chk(deact_cycles == 1, "R11 deact one cycle", deact_cycles, 1);
      chk(ins_flag_o == 0, "R7 no spurious insert", ins_flag_o, 0);
      // R3 later insertion window; R11 negative case
      clr_flags();
      pol_i = pol[0];
      auto_deact_i = 0;
      cd_pin_i = pres;
      wait_flag(0, 100, n);
      chk(n >= 2 * IP + 3 && n <= 3 * IP + 2, "R3 insert latency", n, 3 * IP);
      deact_cycles = 0;
      drive_at_neg();
      cd_pin_i = abs_lvl;
      wait_flag(1, 100, n);
      edges(4);
      chk(n > 0 && deact_cycles == 0, "R11 no deact when disallowed", deact_cycles, 0);
      // R5 insertion pulses up to 2*IP long
      clr_flags();
      for (int len = 1; len <= 2 * IP; len += 3) begin
        drive_at_neg();
        cd_pin_i = pres;
        edges(len);
        drive_at_neg();
        cd_pin_i = abs_lvl;
        edges(SN * IP + 4);
        chk(ins_flag_o == 0, "R5 short insert pulse ignored", ins_flag_o, 0);
      end
      // R8 disable while present: no remove, and no events while off
      drive_at_neg();
      cd_pin_i = pres;
      wait_flag(0, 100, n);
      clr_flags();
      en_i = 0;
      edges(SN * IP * 2);
      chk(rem_flag_o == 0 && ins_flag_o == 0, "R8 disabled no events", {ins_flag_o, rem_flag_o}, 0);
      drive_at_neg();
      cd_pin_i = abs_lvl;
      edges(SN * IP * 2);
      chk(rem_flag_o == 0, "R8 disabled removal ignored", rem_flag_o, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule